// File: doc/BRIEF.md
# Memory Card SPI Start-up Sequencer

This block takes a freshly powered memory card from its native mode into SPI mode, works out which generation of card it is, and leaves the card ready for 512-byte block transfers. It does no bit shifting itself. It drives three things: a byte-level command request (6-bit opcode, 32-bit argument, CRC byte and the number of reply bytes that follow R1) toward a separate command engine, a raw dummy-byte request for the wake-up clocks, and the chip-select and clock-speed selects. The engine returns the R1 reply byte with a completion pulse and a timeout flag.

A one-cycle `start` runs the whole sequence. The block first sends the wake-up bytes with chip select released, then issues the software reset and the interface-condition probe. The probe reply picks one of two operating-condition retry loops: the older one repeats the application prefix and the init command, and the newer one adds an OCR read and a programmable pause to each iteration. Each loop is bounded. The block then sets the block length to 512 and, if that succeeds, switches to the fast clock. The result is a card type and an address-scaling flag. Both are reported with a one-cycle `done` pulse and then held until the next accepted start.

Top module: `card_boot_seq`

## Requirements
- R1: After reset, `done`, `cmd_valid`, `dummy_req`, `cs_req` and `clk_fast` are 0, and `card_type` is 0 (fail). Encoding of `card_type`: 0 = fail, 1 = older standard-capacity card, 2 = newer card.
- R2: After an accepted start, exactly WAKE_BYTES (default 16) dummy bytes are requested before the first command. During them `cs_req` is 0 and `clk_fast` is 0.
- R3: The first command is opcode 0 with argument 0, CRC 0x95 and no trailing bytes. Unless the reply is exactly 0x01 with `cmd_timeout` low, the sequence ends with `card_type` = 0.
- R4: The second command is opcode 8 with argument 0x000001AA, CRC 0x87 and 4 trailing bytes. Reply 0x01 selects the newer path, reply 0x05 selects the older path, and any other reply (or a timeout) ends with `card_type` = 0.
- R5: The older path repeats opcode 55, then opcode 41 with argument 0, until the opcode-41 reply is 0x00. It then reports `card_type` = 1 with `byte_addr_mode` = 1.
- R6: The newer path repeats a pause of at least WAIT_CYCLES clock cycles, then opcode 58 (4 trailing bytes), opcode 55, and opcode 41 with argument 0x40000000, until the opcode-41 reply is 0x00. It then issues one more opcode 58 and reports `card_type` = 2 with `byte_addr_mode` = 0.
- R7: Each retry loop makes at most MAX_TRIES opcode-41 attempts. If the last one is still nonzero, the sequence ends with `card_type` = 0 and no opcode 16 is issued. A reply of 0x00 on exactly the last attempt still succeeds.
- R8: After either loop, opcode 16 is issued with argument 512. A nonzero reply gives `card_type` = 0, `byte_addr_mode` = 0 and `clk_fast` = 0. A zero reply sets `clk_fast` = 1.
- R9: `done` is a one-cycle pulse and `card_type` is valid in that cycle. The result holds until the next accepted start, which clears it to 0 on the following cycle. A start during a running sequence is ignored.
- R10: A command request holds its fields until `cmd_done`. Commands and dummy bytes are never requested together. `cs_req` is 1 exactly while a command is requested. Opcodes 55 and 41 use CRC 0x95 and no trailing bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a start-up sequence (accepted only when idle) |
| done | output | 1 | One-cycle end-of-sequence pulse |
| card_type | output | 2 | 0 fail, 1 older standard card, 2 newer card |
| byte_addr_mode | output | 1 | 1: addresses scale by 512 (byte addressing); 0: block addressing |
| clk_fast | output | 1 | 0: slow start-up clock, 1: fast data clock |
| cs_req | output | 1 | Chip-select asserted request |
| dummy_req | output | 1 | Request one 0xFF byte with chip select released |
| dummy_done | input | 1 | Dummy byte sent |
| cmd_valid | output | 1 | Command request |
| cmd_op | output | 6 | Command opcode |
| cmd_arg | output | 32 | Command argument |
| cmd_crc | output | 8 | CRC byte to send |
| cmd_tail | output | 3 | Reply bytes to read after R1 |
| cmd_done | input | 1 | Command completed, reply valid |
| cmd_r1 | input | 8 | R1 reply byte |
| cmd_timeout | input | 1 | No reply arrived; treated as 0xFF |

## Verification
The card model behind the bench is driven through several reply patterns. These are an older card and a newer card that each stay busy for a few rounds, a newer card's probe reply against an unknown one, a bad reset reply against a timed-out good one, a card that never leaves busy on each path, a card that becomes ready on exactly the last allowed attempt, and a block-length rejection. The logged opcode order shows which branch and how many loop rounds were taken. The field check for each logged command separates the two init arguments and the trailing-byte counts. The final type, scaling flag and clock select show whether success came from the right path or a failure was caught at the right step. A start pulse during a run, a long idle after `done`, and a restart after a success show that the result is held and cleared only when intended.

// File: rtl/card_boot_pkg.sv
package card_boot_pkg;

    typedef enum logic [1:0] {
        KIND_FAIL = 2'd0,
        KIND_OLD  = 2'd1,
        KIND_NEW  = 2'd2
    } card_kind_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_WAKE,
        ST_RESET_CMD,
        ST_PROBE,
        ST_OLD_APP,
        ST_OLD_INIT,
        ST_NEW_PAUSE,
        ST_NEW_OCR,
        ST_NEW_APP,
        ST_NEW_INIT,
        ST_NEW_OCR_END,
        ST_BLKLEN,
        ST_FINISH
    } seq_state_e;

    typedef struct packed {
        logic [5:0]  op;
        logic [31:0] arg;
        logic [7:0]  crc;
        logic [2:0]  tail;
    } cmd_fields_t;

    localparam logic [7:0] R1_IDLE_BIT    = 8'h01;
    localparam logic [7:0] R1_ILLEGAL_BIT = 8'h04;
    localparam logic [7:0] R1_NO_REPLY    = 8'hFF;
    localparam logic [7:0] CRC_DEFAULT    = 8'h95;
    localparam logic [7:0] CRC_PROBE      = 8'h87;
    localparam logic [31:0] PROBE_ARG     = 32'h0000_01AA;
    localparam logic [31:0] HOST_HC_ARG   = 32'h4000_0000;
    localparam logic [31:0] BLOCK_BYTES   = 32'd512;

    function automatic logic is_cmd_state(input seq_state_e s);
        return s inside {ST_RESET_CMD, ST_PROBE, ST_OLD_APP, ST_OLD_INIT,
                         ST_NEW_OCR, ST_NEW_APP, ST_NEW_INIT,
                         ST_NEW_OCR_END, ST_BLKLEN};
    endfunction

endpackage

// File: rtl/cbs_step_counter.sv
module cbs_step_counter #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    output logic last
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] TOP = CW'(LIMIT - 1);

    logic [CW-1:0] count_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            count_q <= '0;
        end else if (inc) begin
            count_q <= (count_q == TOP) ? '0 : count_q + 1'b1;
        end
    end

    assign last = (count_q == TOP);

    // R7: each counted step advances by exactly one
    assert_step_advance_R7: assert property (@(posedge clk) disable iff (rst)
        (inc && !clr && !last) |=> (count_q == $past(count_q) + 1'b1));

endmodule

// File: rtl/cbs_pause_timer.sv
module cbs_pause_timer #(
    parameter int WAIT_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic expired
);
    localparam int TW = $clog2(WAIT_CYCLES + 2);

    logic [TW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
        end else if (load) begin
            left_q <= TW'(WAIT_CYCLES);
        end else if (left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end

    assign expired = (left_q == '0);

    // R6: the pause drains one cycle at a time
    assert_pause_drain_R6: assert property (@(posedge clk) disable iff (rst)
        (!load && left_q != '0) |=> (left_q == $past(left_q) - 1'b1));

endmodule

// File: rtl/cbs_cmd_select.sv
module cbs_cmd_select
    import card_boot_pkg::*;
(
    input  seq_state_e  state,
    output cmd_fields_t fields
);
    always_comb begin
        fields.op   = 6'd0;
        fields.arg  = '0;
        fields.crc  = CRC_DEFAULT;
        fields.tail = 3'd0;
        unique case (state)
            ST_RESET_CMD: fields.op = 6'd0;
            ST_PROBE: begin
                fields.op   = 6'd8;
                fields.arg  = PROBE_ARG;
                fields.crc  = CRC_PROBE;
                fields.tail = 3'd4;
            end
            ST_OLD_APP, ST_NEW_APP: fields.op = 6'd55;
            ST_OLD_INIT: fields.op = 6'd41;
            ST_NEW_INIT: begin
                fields.op  = 6'd41;
                fields.arg = HOST_HC_ARG;
            end
            ST_NEW_OCR, ST_NEW_OCR_END: begin
                fields.op   = 6'd58;
                fields.tail = 3'd4;
            end
            ST_BLKLEN: begin
                fields.op  = 6'd16;
                fields.arg = BLOCK_BYTES;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/card_boot_seq.sv
module card_boot_seq
    import card_boot_pkg::*;
#(
    parameter int WAKE_BYTES  = 16,
    parameter int MAX_TRIES   = 5000,
    parameter int WAIT_CYCLES = 1000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    output logic        done,
    output logic [1:0]  card_type,
    output logic        byte_addr_mode,
    output logic        clk_fast,
    output logic        cs_req,
    output logic        dummy_req,
    input  logic        dummy_done,
    output logic        cmd_valid,
    output logic [5:0]  cmd_op,
    output logic [31:0] cmd_arg,
    output logic [7:0]  cmd_crc,
    output logic [2:0]  cmd_tail,
    input  logic        cmd_done,
    input  logic [7:0]  cmd_r1,
    input  logic        cmd_timeout
);
    seq_state_e  st_q, st_n;
    card_kind_e  kind_q, path_q, path_n;
    logic        byte_q, fast_q;
    logic        fail_now, ok_now, path_set;
    logic        wake_clr, wake_inc, wake_last;
    logic        try_clr, try_inc, try_last;
    logic        pause_load, pause_expired;
    logic [7:0]  reply;
    cmd_fields_t fields;

    assign reply = cmd_timeout ? R1_NO_REPLY : cmd_r1;

    cbs_step_counter #(.LIMIT(WAKE_BYTES)) wake_cnt_i (
        .clk(clk), .rst(rst), .clr(wake_clr), .inc(wake_inc), .last(wake_last));

    cbs_step_counter #(.LIMIT(MAX_TRIES)) try_cnt_i (
        .clk(clk), .rst(rst), .clr(try_clr), .inc(try_inc), .last(try_last));

    cbs_pause_timer #(.WAIT_CYCLES(WAIT_CYCLES)) pause_i (
        .clk(clk), .rst(rst), .load(pause_load), .expired(pause_expired));

    cbs_cmd_select sel_i (.state(st_q), .fields(fields));

    always_comb begin
        st_n       = st_q;
        fail_now   = 1'b0;
        ok_now     = 1'b0;
        path_set   = 1'b0;
        path_n     = path_q;
        wake_clr   = 1'b0;
        wake_inc   = 1'b0;
        try_clr    = 1'b0;
        try_inc    = 1'b0;
        pause_load = 1'b0;
        unique case (st_q)
            ST_IDLE: if (start) begin
                wake_clr = 1'b1;
                st_n     = ST_WAKE;
            end
            ST_WAKE: if (dummy_done) begin
                wake_inc = 1'b1;
                if (wake_last) st_n = ST_RESET_CMD;
            end
            ST_RESET_CMD: if (cmd_done) begin
                if (reply == R1_IDLE_BIT) st_n = ST_PROBE;
                else fail_now = 1'b1;
            end
            ST_PROBE: if (cmd_done) begin
                try_clr  = 1'b1;
                path_set = 1'b1;
                if (reply == R1_IDLE_BIT) begin
                    path_n     = KIND_NEW;
                    pause_load = 1'b1;
                    st_n       = ST_NEW_PAUSE;
                end else if (reply == (R1_IDLE_BIT | R1_ILLEGAL_BIT)) begin
                    path_n = KIND_OLD;
                    st_n   = ST_OLD_APP;
                end else begin
                    path_n   = KIND_FAIL;
                    fail_now = 1'b1;
                end
            end
            ST_OLD_APP: if (cmd_done) st_n = ST_OLD_INIT;
            ST_OLD_INIT: if (cmd_done) begin
                if (reply == 8'h00) st_n = ST_BLKLEN;
                else if (try_last) fail_now = 1'b1;
                else begin
                    try_inc = 1'b1;
                    st_n    = ST_OLD_APP;
                end
            end
            ST_NEW_PAUSE: if (pause_expired) st_n = ST_NEW_OCR;
            ST_NEW_OCR:   if (cmd_done) st_n = ST_NEW_APP;
            ST_NEW_APP:   if (cmd_done) st_n = ST_NEW_INIT;
            ST_NEW_INIT: if (cmd_done) begin
                if (reply == 8'h00) st_n = ST_NEW_OCR_END;
                else if (try_last) fail_now = 1'b1;
                else begin
                    try_inc    = 1'b1;
                    pause_load = 1'b1;
                    st_n       = ST_NEW_PAUSE;
                end
            end
            ST_NEW_OCR_END: if (cmd_done) st_n = ST_BLKLEN;
            ST_BLKLEN: if (cmd_done) begin
                if (reply == 8'h00) begin
                    ok_now = 1'b1;
                    st_n   = ST_FINISH;
                end else fail_now = 1'b1;
            end
            ST_FINISH: st_n = ST_IDLE;
            default:   st_n = ST_IDLE;
        endcase
        if (fail_now) st_n = ST_FINISH;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            kind_q <= KIND_FAIL;
            path_q <= KIND_FAIL;
            byte_q <= 1'b0;
            fast_q <= 1'b0;
        end else begin
            st_q <= st_n;
            if (path_set) path_q <= path_n;
            if (st_q == ST_IDLE && start) begin
                kind_q <= KIND_FAIL;
                byte_q <= 1'b0;
                fast_q <= 1'b0;
            end else if (ok_now) begin
                kind_q <= path_q;
                byte_q <= (path_q == KIND_OLD);
                fast_q <= 1'b1;
            end else if (fail_now) begin
                kind_q <= KIND_FAIL;
                byte_q <= 1'b0;
                fast_q <= 1'b0;
            end
        end
    end

    assign done           = (st_q == ST_FINISH);
    assign card_type      = kind_q;
    assign byte_addr_mode = byte_q;
    assign clk_fast       = fast_q;
    assign dummy_req      = (st_q == ST_WAKE);
    assign cmd_valid      = is_cmd_state(st_q);
    assign cs_req         = cmd_valid;
    assign cmd_op         = fields.op;
    assign cmd_arg        = fields.arg;
    assign cmd_crc        = fields.crc;
    assign cmd_tail       = fields.tail;

    // R2: wake-up bytes go out with chip select released on the slow clock
    assert_wake_slow_R2: assert property (@(posedge clk) disable iff (rst)
        dummy_req |-> (!cs_req && !clk_fast));

    // R8: the fast clock turns on only with a successful result
    assert_fast_on_success_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(clk_fast) |-> (done && card_type != 2'd0));

    // R9: done lasts one cycle
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9: the result moves only at done or right after a start
    assert_result_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !$stable(card_type) |-> (done || $past(start)));

    // R10: a request holds its fields until completion
    assert_req_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_done) |=> (cmd_valid && $stable(cmd_op) && $stable(cmd_arg)));

    // R10: never a command and a dummy byte at once
    assert_req_excl_R10: assert property (@(posedge clk) disable iff (rst)
        !(cmd_valid && dummy_req));

endmodule

// File: tb/card_boot_seq_tb_top.sv
module card_boot_seq_tb_top;
    localparam int TRIES = 6;
    localparam int PAUSE = 12;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        done, byte_addr_mode, clk_fast, cs_req, dummy_req, cmd_valid;
    logic [1:0]  card_type;
    logic        dummy_done = 1'b0;
    logic [5:0]  cmd_op;
    logic [31:0] cmd_arg;
    logic [7:0]  cmd_crc;
    logic [2:0]  cmd_tail;
    logic        cmd_done = 1'b0;
    logic [7:0]  cmd_r1 = 8'h00;
    logic        cmd_timeout = 1'b0;

    card_boot_seq #(.WAKE_BYTES(16), .MAX_TRIES(TRIES), .WAIT_CYCLES(PAUSE)) dut_i (
        .clk(clk), .rst(rst), .start(start), .done(done), .card_type(card_type),
        .byte_addr_mode(byte_addr_mode), .clk_fast(clk_fast), .cs_req(cs_req),
        .dummy_req(dummy_req), .dummy_done(dummy_done), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .cmd_arg(cmd_arg), .cmd_crc(cmd_crc), .cmd_tail(cmd_tail),
        .cmd_done(cmd_done), .cmd_r1(cmd_r1), .cmd_timeout(cmd_timeout));

    always #2 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    // card model settings
    logic [7:0] m_reset_r1, m_probe_r1, m_blk_r1;
    logic       m_reset_to;
    int         m_busy;
    // log of commands
    logic [5:0]  lg_op  [0:63];
    logic [31:0] lg_arg [0:63];
    logic [7:0]  lg_crc [0:63];
    logic [2:0]  lg_tail[0:63];
    int          lg_cyc [0:63];
    int          lg_n, dummy_n, dummy_bad, cs_bad;

    task automatic report(input string tag, input logic ok, input string got, input string exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %s expected %s", tag, got, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    // card model / command engine
    initial begin
        forever begin
            @(negedge clk);
            if (cmd_done || dummy_done) begin
                cmd_done = 1'b0; dummy_done = 1'b0; cmd_timeout = 1'b0;
            end else if (dummy_req) begin
                dummy_done = 1'b1;
                dummy_n++;
                if (lg_n != 0 || cs_req || clk_fast) dummy_bad++;
            end else if (cmd_valid) begin
                if (!cs_req) cs_bad++;
                if (lg_n < 64) begin
                    lg_op[lg_n] = cmd_op; lg_arg[lg_n] = cmd_arg;
                    lg_crc[lg_n] = cmd_crc; lg_tail[lg_n] = cmd_tail; lg_cyc[lg_n] = cyc;
                end
                lg_n++;
                case (cmd_op)
                    6'd0:  begin cmd_r1 = m_reset_r1; cmd_timeout = m_reset_to; end
                    6'd8:  cmd_r1 = m_probe_r1;
                    6'd41: if (m_busy > 0) begin m_busy--; cmd_r1 = 8'h01; end
                           else cmd_r1 = 8'h00;
                    6'd16: cmd_r1 = m_blk_r1;
                    default: cmd_r1 = 8'h01;
                endcase
                cmd_done = 1'b1;
            end else if (cs_req) cs_bad++;
        end
    end

    function automatic string seq_str();
        string s = "";
        for (int i = 0; i < lg_n && i < 64; i++)
            s = {s, $sformatf("%0d,", lg_op[i])};
        return s;
    endfunction

    // expected fields per opcode, computed from the requirements
    task automatic check_fields(input string tag, input logic new_path);
        int bad = 0;
        for (int i = 0; i < lg_n && i < 64; i++) begin
            logic [31:0] ea; logic [7:0] ec; logic [2:0] et;
            ea = 0; ec = 8'h95; et = 0;
            case (lg_op[i])
                6'd8:  begin ea = 32'h000001AA; ec = 8'h87; et = 4; end
                6'd41: ea = new_path ? 32'h40000000 : 32'h0;
                6'd58: et = 4;
                6'd16: ea = 512;
                default: ;
            endcase
            if (lg_arg[i] != ea || lg_crc[i] != ec || lg_tail[i] != et) bad++;
        end
        report(tag, bad == 0, $sformatf("%0d bad", bad), "0 bad");
    endtask

    task automatic run_card(input logic [7:0] r0, input logic to0, input logic [7:0] r8,
                            input int busy, input logic [7:0] r16, input logic poke,
                            input logic chk_clear);
        int guard = 0;
        logic poked = 1'b0;
        m_reset_r1 = r0; m_reset_to = to0; m_probe_r1 = r8; m_busy = busy; m_blk_r1 = r16;
        lg_n = 0; dummy_n = 0; dummy_bad = 0; cs_bad = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        if (chk_clear)
            report("R9 clear on start", card_type == 2'd0 && clk_fast == 1'b0,
                   $sformatf("%0d", card_type), "0");
        while (!done && guard < 20000) begin
            @(negedge clk);
            start = 1'b0;
            if (poke && !poked && lg_n == 3) begin start = 1'b1; poked = 1'b1; end
            guard++;
        end
        start = 1'b0;
    endtask

    task automatic check_result(input string tag, input logic [1:0] et, input logic eb, input logic ef);
        report({tag, " type"}, card_type == et, $sformatf("%0d", card_type), $sformatf("%0d", et));
        report({tag, " scale/clock"}, byte_addr_mode == eb && clk_fast == ef,
               $sformatf("%b%b", byte_addr_mode, clk_fast), $sformatf("%b%b", eb, ef));
    endtask

    task automatic t_reset();
        report("R1 reset", !done && !cmd_valid && !dummy_req && !cs_req && !clk_fast && card_type == 2'd0,
               $sformatf("%b%b%b%b%b%0d", done, cmd_valid, dummy_req, cs_req, clk_fast, card_type), "000000");
    endtask

    task automatic t_new_card();
        int gap_ok = 1;
        run_card(8'h01, 1'b0, 8'h01, 2, 8'h00, 1'b1, 1'b0);
        report("R6 new path order", seq_str() == "0,8,58,55,41,58,55,41,58,55,41,58,16,",
               seq_str(), "0,8,58,55,41,58,55,41,58,55,41,58,16,");
        check_fields("R6 R10 new fields", 1'b1);
        check_result("R6", 2'd2, 1'b0, 1'b1);
        report("R2 wake bytes", dummy_n == 16 && dummy_bad == 0,
               $sformatf("%0d/%0d", dummy_n, dummy_bad), "16/0");
        report("R10 cs only during commands", cs_bad == 0, $sformatf("%0d", cs_bad), "0");
        for (int i = 1; i < lg_n; i++)
            if (lg_op[i] == 6'd58 && (lg_op[i-1] == 6'd41 || lg_op[i-1] == 6'd8) && i < lg_n - 2)
                if (lg_cyc[i] - lg_cyc[i-1] < PAUSE + 1) gap_ok = 0;
        report("R6 pause length", gap_ok == 1, $sformatf("%0d", gap_ok), "1");
        @(negedge clk);
        report("R9 done pulse", !done, $sformatf("%b", done), "0");
        repeat (30) @(negedge clk);
        report("R9 result held", card_type == 2'd2 && clk_fast && !cmd_valid,
               $sformatf("%0d", card_type), "2");
    endtask

    task automatic t_old_card();
        run_card(8'h01, 1'b0, 8'h05, 1, 8'h00, 1'b0, 1'b1);
        report("R5 old path order", seq_str() == "0,8,55,41,55,41,16,", seq_str(), "0,8,55,41,55,41,16,");
        check_fields("R5 R4 old fields", 1'b0);
        check_result("R5", 2'd1, 1'b1, 1'b1);
    endtask

    task automatic t_old_last_try();
        run_card(8'h01, 1'b0, 8'h05, TRIES - 1, 8'h00, 1'b0, 1'b0);
        check_result("R7 ready on last try", 2'd1, 1'b1, 1'b1);
    endtask

    task automatic t_loop_bound(input logic new_path);
        string exp = "0,8,";
        for (int i = 0; i < TRIES; i++) exp = {exp, new_path ? "58,55,41," : "55,41,"};
        run_card(8'h01, 1'b0, new_path ? 8'h01 : 8'h05, 1000, 8'h00, 1'b0, 1'b0);
        report(new_path ? "R7 new bound order" : "R7 old bound order", seq_str() == exp, seq_str(), exp);
        check_result("R7 bound", 2'd0, 1'b0, 1'b0);
    endtask

    task automatic t_reset_bad();
        run_card(8'h00, 1'b0, 8'h01, 0, 8'h00, 1'b0, 1'b0);
        report("R3 bad reset reply order", seq_str() == "0,", seq_str(), "0,");
        check_result("R3 bad reply", 2'd0, 1'b0, 1'b0);
        run_card(8'h01, 1'b1, 8'h01, 0, 8'h00, 1'b0, 1'b0);
        report("R3 timeout order", seq_str() == "0,", seq_str(), "0,");
        check_fields("R3 reset fields", 1'b0);
    endtask

    task automatic t_probe_bad();
        run_card(8'h01, 1'b0, 8'h09, 0, 8'h00, 1'b0, 1'b0);
        report("R4 unknown probe order", seq_str() == "0,8,", seq_str(), "0,8,");
        check_result("R4 unknown probe", 2'd0, 1'b0, 1'b0);
    endtask

    task automatic t_blklen_bad();
        run_card(8'h01, 1'b0, 8'h05, 0, 8'h04, 1'b0, 1'b0);
        report("R8 blklen order", seq_str() == "0,8,55,41,16,", seq_str(), "0,8,55,41,16,");
        check_result("R8 blklen reject", 2'd0, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_new_card();
        t_old_card();
        t_old_last_try();
        t_loop_bound(1'b0);
        t_loop_bound(1'b1);
        t_reset_bad();
        t_probe_bad();
        t_blklen_bad();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule